// File: doc/BRIEF.md
# Parametric Funnel Shifter

This block slides an N-bit operand sideways by a run-time amount in a single combinational pass. Internally it forms a 2N-bit word from two N-bit halves and extracts an N-bit window that starts a chosen number of positions into that word. The window moves through a cascade of log2(N) stages. Each stage either moves the word by its own power of two or passes it through, under one bit of the amount.

The bits that slide into the window are not a fixed constant. They come from the other half of the 2N-bit word. A small front-end chooses what goes into each half, and that choice alone gives the different behaviours. Zeros next to the operand give a logical shift. Copies of the sign bit above the operand give an arithmetic right shift. The operand placed in both halves gives a rotate. A direction input picks whether the window slides toward the low end or the high end. The block holds no state and is meant to sit inside one cycle of a datapath, such as an ALU shift lane or a normalisation step.

Top module: `funnel_shift_unit`

## Requirements
- R1: With direction right (`dir_right_i`=1) and mode 2'b00, `result_o` equals `opnd_i` shifted toward bit 0 by `amt_i` places, with zeros entering at bit N-1.
- R2: With direction left (`dir_right_i`=0) and mode 2'b00, 2'b01 or 2'b11, `result_o` equals `opnd_i` shifted toward bit N-1 by `amt_i` places, with zeros entering at bit 0. Selecting the arithmetic mode with left direction therefore gives a logical left shift.
- R3: With direction right and mode 2'b01, vacated high bits take the value of `opnd_i[N-1]`. Read as two's complement, the result is floor(`opnd_i` / 2^`amt_i`); for example -8 by 1 gives -4, and -15 by 2 gives -4.
- R4: With direction right and mode 2'b10, `result_o` is `opnd_i` rotated toward bit 0 by `amt_i` places. Bits leaving bit 0 re-enter at bit N-1, and no bit is lost.
- R5: With direction left and mode 2'b10, `result_o` is `opnd_i` rotated toward bit N-1 by `amt_i` places. Bits leaving bit N-1 re-enter at bit 0.
- R6: When `amt_i` is 0, `result_o` equals `opnd_i` in every mode and in both directions. When the operand is all zeros, the output is all zeros.
- R7: Mode 2'b11 behaves exactly like mode 2'b00 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | N | Operand to shift or rotate |
| amt_i | input | $clog2(N) | Shift amount, 0 to N-1 |
| dir_right_i | input | 1 | 1 = slide toward bit 0, 0 = slide toward bit N-1 |
| mode_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 treated as logical |
| result_o | output | N | Shifted or rotated operand |

## Verification
The bench builds three copies of the block, with N set to 8, 16 and 32. This exercises cascades of three, four and five stages, so an error in a slice bound or in the stage count shows up at one of those widths. At every width, the bench sweeps every legal amount for all four mode codes and both directions. It uses operands that have the top bit set and operands that do not, so the sign fill and the zero fill give different answers. Directed negative operands then confirm the floor-division result of the arithmetic right shift.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  typedef enum logic [1:0] {
    FSH_LOGIC = 2'b00,
    FSH_ARITH = 2'b01,
    FSH_ROTAT = 2'b10,
    FSH_SPARE = 2'b11
  } fsh_mode_e;

  // Half-word role chosen by the front-end.
  typedef enum logic [1:0] {
    HALF_ZERO = 2'b00,
    HALF_DATA = 2'b01,
    HALF_SIGN = 2'b10
  } fsh_half_e;

  // Role of the upper half of the 2N-bit word.
  function automatic fsh_half_e upper_role(input fsh_mode_e m, input logic right);
    if (m == FSH_ROTAT)       return HALF_DATA;
    else if (!right)          return HALF_DATA;
    else if (m == FSH_ARITH)  return HALF_SIGN;
    else                      return HALF_ZERO;
  endfunction

  // Role of the lower half of the 2N-bit word.
  function automatic fsh_half_e lower_role(input fsh_mode_e m, input logic right);
    if (m == FSH_ROTAT)       return HALF_DATA;
    else if (right)           return HALF_DATA;
    else                      return HALF_ZERO;
  endfunction

endpackage

// File: rtl/fsh_operand_sel.sv
module fsh_operand_sel
  import fsh_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] opnd_i,
  input  logic [1:0]   mode_i,
  input  logic         dir_right_i,
  output logic [N-1:0] hi_o,
  output logic [N-1:0] lo_o
);

  fsh_mode_e mode_w;
  fsh_half_e hi_role_w;
  fsh_half_e lo_role_w;
  logic      sign_w;

  assign mode_w    = fsh_mode_e'(mode_i);
  assign hi_role_w = upper_role(mode_w, dir_right_i);
  assign lo_role_w = lower_role(mode_w, dir_right_i);
  assign sign_w    = opnd_i[N-1];

  always_comb begin
    unique case (hi_role_w)
      HALF_DATA: hi_o = opnd_i;
      HALF_SIGN: hi_o = {N{sign_w}};
      default:   hi_o = '0;
    endcase
  end

  always_comb begin
    unique case (lo_role_w)
      HALF_DATA: lo_o = opnd_i;
      HALF_SIGN: lo_o = {N{sign_w}};
      default:   lo_o = '0;
    endcase
  end

endmodule

// File: rtl/fsh_stage.sv
module fsh_stage #(
  parameter int W  = 64,
  parameter int SH = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  input  logic         right_i,
  output logic [W-1:0] d_o
);

  logic [W-1:0] to_low_w;
  logic [W-1:0] to_high_w;

  assign to_low_w  = {{SH{1'b0}}, d_i[W-1:SH]};
  assign to_high_w = {d_i[W-1-SH:0], {SH{1'b0}}};

  always_comb begin
    if (!en_i)        d_o = d_i;
    else if (right_i) d_o = to_low_w;
    else              d_o = to_high_w;
  end

endmodule

// File: rtl/fsh_window.sv
module fsh_window #(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  hi_i,
  input  logic [N-1:0]  lo_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  output logic [N-1:0]  win_o
);

  localparam int W = 2 * N;

  logic [W-1:0] chain_w [SW+1];

  assign chain_w[0] = {hi_i, lo_i};

  for (genvar k = 0; k < SW; k++) begin : g_stage
    fsh_stage #(
      .W  (W),
      .SH (1 << k)
    ) u_stage (
      .d_i     (chain_w[k]),
      .en_i    (amt_i[k]),
      .right_i (right_i),
      .d_o     (chain_w[k+1])
    );
  end

  assign win_o = right_i ? chain_w[SW][N-1:0] : chain_w[SW][W-1:N];

endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit #(
  parameter int N = 32,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  opnd_i,
  input  logic [SW-1:0] amt_i,
  input  logic          dir_right_i,
  input  logic [1:0]    mode_i,
  output logic [N-1:0]  result_o
);

  logic [N-1:0] hi_w;
  logic [N-1:0] lo_w;

  fsh_operand_sel #(.N(N)) u_sel (
    .opnd_i      (opnd_i),
    .mode_i      (mode_i),
    .dir_right_i (dir_right_i),
    .hi_o        (hi_w),
    .lo_o        (lo_w)
  );

  fsh_window #(.N(N), .SW(SW)) u_win (
    .hi_i    (hi_w),
    .lo_i    (lo_w),
    .amt_i   (amt_i),
    .right_i (dir_right_i),
    .win_o   (result_o)
  );

endmodule

// File: rtl/fsh_checker.sv
module fsh_checker #(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input logic [N-1:0]  opnd_i,
  input logic [SW-1:0] amt_i,
  input logic          dir_right_i,
  input logic [1:0]    mode_i,
  input logic [N-1:0]  hi_w,
  input logic [N-1:0]  lo_w,
  input logic [N-1:0]  result_o
);

  always_comb begin
    if (amt_i == '0) begin
      // R6
      zero_amt_chk: assert (result_o == opnd_i);
    end
    if (dir_right_i && (mode_i == 2'b00 || mode_i == 2'b11)) begin
      // R1
      right_zero_fill_chk: assert (hi_w == '0 && lo_w == opnd_i);
    end
    if (!dir_right_i && mode_i != 2'b10) begin
      // R2
      left_zero_fill_chk: assert (lo_w == '0 && hi_w == opnd_i);
    end
    if (dir_right_i && mode_i == 2'b01) begin
      // R3
      sign_kept_chk: assert (result_o[N-1] == opnd_i[N-1]);
    end
    if (mode_i == 2'b10) begin
      // R4
      rotate_keeps_bits_chk: assert ($countones(result_o) == $countones(opnd_i));
      // R5
      rotate_halves_chk: assert (hi_w == lo_w);
    end
  end

endmodule

bind funnel_shift_unit fsh_checker #(.N(N), .SW(SW)) u_chk (
  .opnd_i      (opnd_i),
  .amt_i       (amt_i),
  .dir_right_i (dir_right_i),
  .mode_i      (mode_i),
  .hi_w        (hi_w),
  .lo_w        (lo_w),
  .result_o    (result_o)
);

// File: tb/funnel_shift_unit_tb.sv
module funnel_shift_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  op8;   logic [2:0] am8;   logic [7:0]  r8;
  logic [15:0] op16;  logic [3:0] am16;  logic [15:0] r16;
  logic [31:0] op32;  logic [4:0] am32;  logic [31:0] r32;
  logic        dir_r;
  logic [1:0]  mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  funnel_shift_unit #(.N(8)) u_dut8 (
    .opnd_i(op8), .amt_i(am8), .dir_right_i(dir_r), .mode_i(mode), .result_o(r8));
  funnel_shift_unit #(.N(16)) u_dut16 (
    .opnd_i(op16), .amt_i(am16), .dir_right_i(dir_r), .mode_i(mode), .result_o(r16));
  funnel_shift_unit #(.N(32)) u_dut (
    .opnd_i(op32), .amt_i(am32), .dir_right_i(dir_r), .mode_i(mode), .result_o(r32));

  // Arithmetic model over a 64-bit container, width w.
  function automatic logic [63:0] model(input logic [63:0] d, input int s,
                                        input logic right, input logic [1:0] md,
                                        input int w);
    logic [63:0] m;
    logic [63:0] dm;
    logic signed [63:0] sx;
    m  = (64'd1 << w) - 64'd1;
    dm = d & m;
    if (md == 2'b10 && right) return ((dm >> s) | (dm << (w - s))) & m;
    if (md == 2'b10)          return ((dm << s) | (dm >> (w - s))) & m;
    if (!right)               return (dm << s) & m;
    if (md == 2'b01) begin
      sx = dm[w-1] ? $signed(dm | ~m) : $signed(dm);
      return 64'(sx >>> s) & m;
    end
    return dm >> s;
  endfunction

  function automatic string tag_of(input int s, input logic right, input logic [1:0] md);
    if (s == 0)                return "R6";
    if (md == 2'b11)           return "R7";
    if (md == 2'b10 && right)  return "R4";
    if (md == 2'b10)           return "R5";
    if (!right)                return "R2";
    if (md == 2'b01)           return "R3";
    return "R1";
  endfunction

  task automatic check(input string tag, input int w, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s N=%0d mode=%b right=%b act=%h exp=%h",
               tag, w, mode, dir_r, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input int s, input logic right,
                       input logic [1:0] md);
    @(posedge clk);
    op8 = d[7:0]; op16 = d[15:0]; op32 = d;
    am8 = 3'(s); am16 = 4'(s); am32 = 5'(s);
    dir_r = right; mode = md;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hF3A5_0F8F;
    pats[1] = 32'h8000_8081;
    pats[2] = 32'h5A3C_6E71;
    pats[3] = 32'hFFFF_FFFF;

    // R6: all-zero operand gives all-zero result
    drive(32'h0, 5, 1'b1, 2'b01);
    check("R6", 8,  {56'd0, r8},  64'd0);
    check("R6", 16, {48'd0, r16}, 64'd0);
    check("R6", 32, {32'd0, r32}, 64'd0);

    for (int p = 0; p < 4; p++) begin
      for (int md = 0; md < 4; md++) begin
        for (int r = 0; r < 2; r++) begin
          for (int s = 0; s < 32; s++) begin
            drive(pats[p], s, r[0], md[1:0]);
            if (s < 8)
              check(tag_of(s, r[0], md[1:0]), 8, {56'd0, r8},
                    model({32'd0, pats[p]}, s, r[0], md[1:0], 8));
            if (s < 16)
              check(tag_of(s, r[0], md[1:0]), 16, {48'd0, r16},
                    model({32'd0, pats[p]}, s, r[0], md[1:0], 16));
            check(tag_of(s, r[0], md[1:0]), 32, {32'd0, r32},
                  model({32'd0, pats[p]}, s, r[0], md[1:0], 32));
          end
        end
      end
    end

    // R3: directed signed floor-division cases
    drive(32'hFFFF_FFF8, 1, 1'b1, 2'b01);          // -8 >> 1 = -4
    check("R3", 32, {32'd0, r32}, {32'd0, 32'hFFFF_FFFC});
    drive(32'hFFFF_FFF1, 2, 1'b1, 2'b01);          // -15 >> 2 = -4
    check("R3", 32, {32'd0, r32}, {32'd0, 32'hFFFF_FFFC});
    check("R3", 8,  {56'd0, r8},  {56'd0, 8'hFC});
    drive(32'h0000_0080, 7, 1'b1, 2'b01);          // N=8: -128 >> 7 = -1
    check("R3", 8,  {56'd0, r8},  {56'd0, 8'hFF});
    drive(32'h0000_0070, 4, 1'b1, 2'b01);          // N=8: 112 >> 4 = 7
    check("R3", 8,  {56'd0, r8},  {56'd0, 8'h07});
    // R2: arithmetic mode with left direction zero-fills
    drive(32'h8000_0001, 31, 1'b0, 2'b01);
    check("R2", 32, {32'd0, r32}, {32'd0, 32'h8000_0000});

    finish_run();
  end

endmodule